// File: doc/BRIEF.md
# Audio Transmit FIFO with Threshold Interrupts

This block buffers 32-bit audio words between a register-write port and a downstream serializer. Software or a DMA engine writes words in. The serializer pops them in order. The current fill level is always visible as a count from 0 to the full depth.

Two interrupt sources are provided. A transmit-empty condition is raised while the fill level has fallen to a programmable threshold or below, which lets software refill the buffer in bursts. An underflow condition latches when the serializer pops from an empty buffer, and stays latched until software clears it. A DMA request follows the same below-watermark rule, with its own level and enable. A flush command empties the buffer. Its busy flag reads as 1 until the flush completes and then drops by itself.

Top module: `audio_tx_fifo`

## Requirements
- R1: Once reset is released, level_o is 0, flush_busy_o is 0 and under_st_o is 0.
- R2: Accepted words leave in the order they were written. pop_data_o shows the oldest stored word while level_o is nonzero. A push alone raises level_o by one and a pop alone lowers it by one, on the next clock edge.
- R3: A push while level_o equals the depth (32) is dropped: the level stays 32 and the dropped word never appears at pop_data_o.
- R4: level_o is a 6-bit count of stored words, ranging from 0 to 32.
- R5: empty_st_o is 1 exactly when level_o is less than or equal to thresh_i (5 bits).
- R6: A pop while level_o is 0 and no flush is in progress sets under_st_o on the next edge. under_st_o then stays 1 until a cycle with under_clr_i high. If an underflowing pop and under_clr_i occur in the same cycle, the set wins.
- R7: irq_o equals (empty_st_o AND empty_ie_i) OR (under_st_o AND under_ie_i).
- R8: flush_i high while no flush is busy makes flush_busy_o read 1 for one cycle. On the following edge the level becomes 0 and flush_busy_o returns to 0. Pushes and pops made while flush_busy_o is 1 have no effect, and flush_i is ignored while busy.
- R9: dma_req_o is 1 exactly when dma_en_i is 1 and level_o is less than or equal to dma_wm_i (5 bits).
- R10: A push and a pop in the same cycle at a level strictly between 0 and 32 leave the level unchanged. At level 0 such a pair stores the pushed word and flags underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Write strobe from the register port |
| push_data_i | input | 32 | Word to store |
| pop_i | input | 1 | Serializer takes the oldest word |
| pop_data_o | output | 32 | Oldest stored word |
| level_o | output | 6 | Fill level |
| thresh_i | input | 5 | Empty-interrupt threshold |
| empty_ie_i | input | 1 | Empty-interrupt enable |
| under_ie_i | input | 1 | Underflow-interrupt enable |
| under_clr_i | input | 1 | Underflow status clear |
| flush_i | input | 1 | Flush command |
| flush_busy_o | output | 1 | Flush in progress |
| dma_en_i | input | 1 | DMA request enable |
| dma_wm_i | input | 5 | DMA watermark level |
| empty_st_o | output | 1 | Raw transmit-empty status |
| under_st_o | output | 1 | Raw underflow status |
| dma_req_o | output | 1 | DMA request |
| irq_o | output | 1 | Combined interrupt |

## Verification
The buffer is filled to overflow with a counting pattern. This shows whether a dropped 33rd word corrupts the stored words or the level. It is then drained with interleaved push-and-pop cycles, which show whether simultaneous operations keep the level steady and the order intact. Pops at empty, with and without a clear in the same cycle, show the priority of set over clear and the stickiness of the underflow flag. The threshold, watermark and enables are swept across levels so that the at-or-below comparison is distinguished from a strict one. A flush during a push burst shows that words sent while busy are discarded.

// File: rtl/atf_pkg.sv
package atf_pkg;
  parameter int unsigned ATF_DEPTH = 32;
  parameter int unsigned ATF_WIDTH = 32;
endpackage

// File: rtl/atf_storage.sv
module atf_storage #(
  parameter int unsigned DEPTH = atf_pkg::ATF_DEPTH,
  parameter int unsigned WIDTH = atf_pkg::ATF_WIDTH,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  input  logic             clear_i,
  input  logic             hold_i,
  output logic [WIDTH-1:0] pop_data_o,
  output logic [LW-1:0]    level_o,
  output logic             pop_empty_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [LW-1:0]    level_q;
  logic             push_ok, pop_ok;

  assign push_ok     = push_i && !hold_i && (level_q != LW'(DEPTH));
  assign pop_ok      = pop_i && !hold_i && (level_q != '0);
  assign pop_empty_o = pop_i && !hold_i && (level_q == '0);

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (clear_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (pop_ok)  rd_ptr_q <= rd_ptr_q + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + LW'(1);
        2'b01:   level_q <= level_q - LW'(1);
        default: level_q <= level_q;
      endcase
    end
  end

  assign pop_data_o = mem[rd_ptr_q];
  assign level_o    = level_q;
endmodule

// File: rtl/atf_flush.sv
module atf_flush (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  output logic busy_o
);
  logic busy_q;

  // busy lasts one cycle; the clear is applied on the edge that drops it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_q <= 1'b0;
    else if (busy_q) busy_q <= 1'b0;
    else             busy_q <= flush_i;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/atf_irq.sv
module atf_irq #(
  parameter int unsigned DEPTH = atf_pkg::ATF_DEPTH,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] level_i,
  input  logic [AW-1:0] thresh_i,
  input  logic [AW-1:0] dma_wm_i,
  input  logic          dma_en_i,
  input  logic          empty_ie_i,
  input  logic          under_ie_i,
  input  logic          under_set_i,
  input  logic          under_clr_i,
  output logic          empty_st_o,
  output logic          under_st_o,
  output logic          dma_req_o,
  output logic          irq_o
);
  logic under_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          under_q <= 1'b0;
    else if (under_set_i) under_q <= 1'b1;
    else if (under_clr_i) under_q <= 1'b0;
  end

  assign empty_st_o = (level_i <= {1'b0, thresh_i});
  assign dma_req_o  = dma_en_i && (level_i <= {1'b0, dma_wm_i});
  assign under_st_o = under_q;
  assign irq_o      = (empty_st_o && empty_ie_i) || (under_q && under_ie_i);
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo #(
  parameter int unsigned DEPTH = atf_pkg::ATF_DEPTH,
  parameter int unsigned WIDTH = atf_pkg::ATF_WIDTH,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] pop_data_o,
  output logic [LW-1:0]    level_o,
  input  logic [AW-1:0]    thresh_i,
  input  logic             empty_ie_i,
  input  logic             under_ie_i,
  input  logic             under_clr_i,
  input  logic             flush_i,
  output logic             flush_busy_o,
  input  logic             dma_en_i,
  input  logic [AW-1:0]    dma_wm_i,
  output logic             empty_st_o,
  output logic             under_st_o,
  output logic             dma_req_o,
  output logic             irq_o
);
  logic          busy;
  logic          under_set;
  logic [LW-1:0] level;

  atf_flush u_flush (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush_i),
    .busy_o (busy)
  );

  atf_storage #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_i),
    .push_data_i(push_data_i),
    .pop_i      (pop_i),
    .clear_i    (busy),
    .hold_i     (busy),
    .pop_data_o (pop_data_o),
    .level_o    (level),
    .pop_empty_o(under_set)
  );

  atf_irq #(.DEPTH(DEPTH)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_i    (level),
    .thresh_i   (thresh_i),
    .dma_wm_i   (dma_wm_i),
    .dma_en_i   (dma_en_i),
    .empty_ie_i (empty_ie_i),
    .under_ie_i (under_ie_i),
    .under_set_i(under_set),
    .under_clr_i(under_clr_i),
    .empty_st_o (empty_st_o),
    .under_st_o (under_st_o),
    .dma_req_o  (dma_req_o),
    .irq_o      (irq_o)
  );

  assign level_o      = level;
  assign flush_busy_o = busy;
endmodule

// File: rtl/atf_checker.sv
module atf_checker #(
  parameter int unsigned DEPTH = atf_pkg::ATF_DEPTH,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = AW + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push_i,
  input logic          pop_i,
  input logic          flush_i,
  input logic          under_clr_i,
  input logic          flush_busy_o,
  input logic          under_st_o,
  input logic [LW-1:0] level_o
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LW'(DEPTH)); // R4

  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == LW'(DEPTH) && push_i && !pop_i && !flush_busy_o) |=> level_o == LW'(DEPTH)); // R3

  AST_PUSH_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !flush_busy_o && level_o < LW'(DEPTH)) |=> level_o == $past(level_o) + LW'(1)); // R2

  AST_UNDER_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && level_o == '0 && !flush_busy_o) |=> under_st_o); // R6

  AST_UNDER_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (under_st_o && !under_clr_i) |=> under_st_o); // R6

  AST_FLUSH_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !flush_busy_o) |=> flush_busy_o); // R8

  AST_FLUSH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_busy_o |=> (!flush_busy_o && level_o == '0)); // R8

  AST_PAIR_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !flush_busy_o && level_o != '0 && level_o != LW'(DEPTH)) |=> $stable(level_o)); // R10
endmodule

bind audio_tx_fifo atf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .flush_i     (flush_i),
  .under_clr_i (under_clr_i),
  .flush_busy_o(flush_busy_o),
  .under_st_o  (under_st_o),
  .level_o     (level_o)
);

// File: tb/audio_tx_fifo_tb.sv
module audio_tx_fifo_tb;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 1'b0, pop_i = 1'b0;
  logic [31:0] push_data_i = '0;
  logic [31:0] pop_data_o;
  logic [5:0]  level_o;
  logic [4:0]  thresh_i = 5'd16, dma_wm_i = 5'd8;
  logic        empty_ie_i = 1'b0, under_ie_i = 1'b0, under_clr_i = 1'b0;
  logic        flush_i = 1'b0, dma_en_i = 1'b0;
  logic        flush_busy_o, empty_st_o, under_st_o, dma_req_o, irq_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] sb_q [$];
  logic        m_busy = 1'b0, m_under = 1'b0, mon_on = 1'b0;

  always #10 clk = ~clk;

  audio_tx_fifo u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push_i), .push_data_i(push_data_i),
    .pop_i(pop_i), .pop_data_o(pop_data_o), .level_o(level_o), .thresh_i(thresh_i),
    .empty_ie_i(empty_ie_i), .under_ie_i(under_ie_i), .under_clr_i(under_clr_i),
    .flush_i(flush_i), .flush_busy_o(flush_busy_o), .dma_en_i(dma_en_i),
    .dma_wm_i(dma_wm_i), .empty_st_o(empty_st_o), .under_st_o(under_st_o),
    .dma_req_o(dma_req_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // driver: one cycle of stimulus, applied at the falling edge
  task automatic cyc(input logic ps, input logic [31:0] d, input logic pp,
                     input logic clr = 1'b0, input logic fl = 1'b0);
    @(negedge clk);
    push_i = ps; push_data_i = d; pop_i = pp; under_clr_i = clr; flush_i = fl;
  endtask

  // monitor and scoreboard, sampled mid low phase
  initial begin
    forever begin
      int sz;
      logic exp_empty, exp_irq;
      @(negedge clk); #5;
      if (mon_on) begin
        sz = sb_q.size();
        exp_empty = (sz <= int'(thresh_i));
        exp_irq = (exp_empty && empty_ie_i) || (m_under && under_ie_i);
        check("R4 level", 32'(level_o), 32'(sz));
        check("R8 busy", 32'(flush_busy_o), 32'(m_busy));
        check("R5 empty_st", 32'(empty_st_o), 32'(exp_empty));
        check("R9 dma_req", 32'(dma_req_o), 32'(dma_en_i && sz <= int'(dma_wm_i)));
        check("R6 under_st", 32'(under_st_o), 32'(m_under));
        check("R7 irq", 32'(irq_o), 32'(exp_irq));
        if (pop_i && !m_busy && sz > 0) check("R2 order", pop_data_o, sb_q[0]);
        if (pop_i && !m_busy && sz == 0) m_under = 1'b1;
        else if (under_clr_i) m_under = 1'b0;
        if (m_busy) begin
          sb_q.delete();
          m_busy = 1'b0;
        end else begin
          if (pop_i && sz > 0) void'(sb_q.pop_front());
          if (push_i && sz < DEPTH) sb_q.push_back(push_data_i);
          m_busy = flush_i;
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #35 rst_ni = 1'b1;
    #10;
    check("R1 level", 32'(level_o), 0);
    check("R1 busy", 32'(flush_busy_o), 0);
    check("R1 under", 32'(under_st_o), 0);
    mon_on = 1'b1;
    empty_ie_i = 1'b1; under_ie_i = 1'b1; dma_en_i = 1'b1;
    // R3: overfill with a counting pattern
    for (int i = 0; i < DEPTH + 3; i++) cyc(1'b1, 32'hA000_0000 + 32'(i), 1'b0);
    cyc(1'b0, 0, 1'b0);
    #6 check("R3 full level", 32'(level_o), 32);
    // R10 interleaved push and pop at a mid level
    for (int i = 0; i < 10; i++) cyc(1'b0, 0, 1'b1);
    for (int i = 0; i < 12; i++) cyc(1'b1, 32'hB000_0000 + 32'(i), 1'b1);
    // sweep threshold and watermark while draining
    for (int i = 0; i < 30; i++) begin
      cyc(1'b0, 0, 1'b1);
      thresh_i = 5'(i); dma_wm_i = 5'(31 - i);
    end
    cyc(1'b0, 0, 1'b0);
    #6 check("R2 drained", 32'(level_o), 0);
    // R6 underflow: pop at empty, then sticky
    cyc(1'b0, 0, 1'b1);
    cyc(1'b0, 0, 1'b0);
    cyc(1'b0, 0, 1'b0);
    #6 check("R6 sticky", 32'(under_st_o), 1);
    cyc(1'b0, 0, 1'b0, 1'b1);
    under_ie_i = 1'b0; empty_ie_i = 1'b0;
    // R6 set wins over clear; R10 push+pop at empty
    cyc(1'b1, 32'hC0DE_0001, 1'b1, 1'b1);
    cyc(1'b0, 0, 1'b0);
    #6 check("R10 pair at empty", 32'(level_o), 1);
    check("R6 set over clear", 32'(under_st_o), 1);
    cyc(1'b0, 0, 1'b0, 1'b1);
    under_ie_i = 1'b1; thresh_i = 5'd3;
    // R8 flush with content, pushes during busy ignored
    for (int i = 0; i < 6; i++) cyc(1'b1, 32'hD000_0000 + 32'(i), 1'b0);
    cyc(1'b1, 32'hD000_0006, 1'b0, 1'b0, 1'b1);
    cyc(1'b1, 32'hDEAD_0000, 1'b1, 1'b0, 1'b1);
    cyc(1'b0, 0, 1'b0);
    #6 check("R8 flushed", 32'(level_o), 0);
    check("R8 no underflow while busy", 32'(under_st_o), 0);
    // refill after flush, order restarts cleanly
    for (int i = 0; i < 5; i++) cyc(1'b1, 32'hE000_0000 + 32'(i), 1'b0);
    for (int i = 0; i < 5; i++) cyc(1'b0, 0, 1'b1);
    dma_en_i = 1'b0; empty_ie_i = 1'b1;
    cyc(1'b0, 0, 1'b0);
    cyc(1'b0, 0, 1'b0);
    @(negedge clk); #6;
    mon_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule